// File: doc/BRIEF.md
# One-Hot Token-Flow Sequencing Controller

This clocked controller steps a small fixed program. Its state register is a literal image of the marking of a safe control net: each place has its own flip-flop, and a flip-flop is set while that place holds a token. The program loops forever through four steps:

- It tests a condition bit.
- If the condition is true, it forks into two concurrent operations and joins when both are finished.
- If the condition is false, it runs two other operations one after the other.
- The two branches merge and control returns to the test.

Each operation drives an external datapath unit through a four-phase request/acknowledge pair. The surrounding logic can observe the place vector at any time.

The design has two parts.

- **Operation cells.** Each of the four operation cells runs one handshake. Its phase enum holds three states. `PH_IDLE` means the place is empty. `PH_REQ` means the request is high and the cell waits for the acknowledge to rise. `PH_REL` means the request is low and the cell waits for the acknowledge to fall.
- **Net core.** The net core holds the places with no handshake of their own: the test place and the two join places. It fires the net's transitions:
  - `t_choose` is the choice on the condition. When the condition is true it also acts as the fork dummy.
  - `t_seq` is the linear step from the third operation to the fourth.
  - `t_join` is the join dummy.
  - `t_merge` is the merge dummy back into the test place. It fires either from the join or from the end of the fourth operation.

Top module: `tokseq_ctrl`

## Requirements
- R1: During and right after reset, `marking_o` is 7'b0000001 and every `req_o` bit is 0. The place bit positions are: 0 test, 1 op1 running, 2 op2 running, 3 op1 finished/awaiting join, 4 op2 finished/awaiting join, 5 op3 running, 6 op4 running. `req_o[k]` and `ack_i[k]` belong to operation k+1.
- R2: When the test place is marked at a clock edge, the token leaves it at that edge. If `cond_i` is 1, places 1 and 2 become marked and `req_o[0]` and `req_o[1]` go high. If `cond_i` is 0, place 5 becomes marked and `req_o[2]` goes high.
- R3: `cond_i` is sampled only at the edge where the test place fires. Changes of `cond_i` at any other time do not alter the branch taken in that iteration.
- R4: A request stays high while its acknowledge is low. The request drops at the first edge at which its acknowledge is high. The place stays marked until an edge at which the acknowledge is low again.
- R5: When op1 or op2 finishes, its running place clears and its join place sets. A single join place stays marked until the other one is marked too, whichever operation finishes first.
- R6: The op4 request rises exactly at the edge where op3's acknowledge is sampled low after op3's request was dropped. At that edge, place 5 clears and place 6 sets.
- R7: Control returns to the test place one edge after both join places are marked, or at the edge where op4 completes its handshake. The loop then repeats indefinitely.
- R8: Operations of the parallel branch (places 1 to 4) and of the sequential branch (places 5 and 6) are never marked together, and op3 and op4 are never requested together.
- R9: Whenever the test place is marked, no other place is marked and no request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 1 | Condition tested by the choice transition |
| ack_i | input | 4 | Acknowledge from each operation's datapath unit |
| req_o | output | 4 | Request to each operation's datapath unit |
| marking_o | output | 7 | Current place vector (one bit per place) |

## Verification
The condition bit is driven randomly on every cycle. This shows that only the value present at the choice edge decides the branch, even when the bit flips while an operation is running.

The acknowledges come from a responder whose delays cycle through four patterns:
- all delays zero, which exercises the shortest back-to-back handshakes;
- op1 faster than op2, and op2 faster than op1, which make each join place the early one in turn so that the join must wait for the late one;
- random delays, which mix both orders and stress the step from op3 to op4.

A behavioural marking model is compared against the outputs on every cycle. It is backed by event checks on choice, join, sequence and merge timing.

// File: rtl/tokseq_pkg.sv
package tokseq_pkg;

    localparam int NUM_OPS    = 4;
    localparam int NUM_PLACES = 7;

    // place positions in the observable vector
    localparam int PL_TEST = 0;
    localparam int PL_RUN1 = 1;
    localparam int PL_RUN2 = 2;
    localparam int PL_JN1  = 3;
    localparam int PL_JN2  = 4;
    localparam int PL_RUN3 = 5;
    localparam int PL_RUN4 = 6;

    // operation slots
    localparam int OP_PAR_A = 0;
    localparam int OP_PAR_B = 1;
    localparam int OP_SEQ_A = 2;
    localparam int OP_SEQ_B = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_REL  = 2'd2
    } hs_phase_t;

endpackage

// File: rtl/hs_op_cell.sv
module hs_op_cell
    import tokseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic ack_i,
    output logic req_o,
    output logic busy_o,
    output logic done_o
);

    hs_phase_t phase_q;
    hs_phase_t phase_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // next state and outputs
    always_comb begin
        phase_d = phase_q;
        req_o   = 1'b0;
        busy_o  = 1'b1;
        done_o  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                busy_o = 1'b0;
                if (fire_i) begin
                    phase_d = PH_REQ;
                end
            end
            PH_REQ: begin
                req_o = 1'b1;
                if (ack_i) begin
                    phase_d = PH_REL;
                end
            end
            PH_REL: begin
                if (!ack_i) begin
                    phase_d = PH_IDLE;
                    done_o  = 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // R4: request held until acknowledge arrives
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);

    // R4: request dropped once acknowledge seen
    a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> (!req_o && busy_o));

    // R8: a token never enters a place that is already marked
    a_r8_fire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> !busy_o);

endmodule

// File: rtl/tok_net_core.sv
module tok_net_core
    import tokseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cond_i,
    input  logic [NUM_OPS-1:0]    busy_i,
    input  logic [NUM_OPS-1:0]    done_i,
    output logic [NUM_OPS-1:0]    fire_o,
    output logic [NUM_PLACES-1:0] marking_o
);

    logic test_q, jn1_q, jn2_q;
    logic test_d, jn1_d, jn2_d;
    logic t_choose, t_join, t_seq, t_merge;

    // place register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_q <= 1'b1;
            jn1_q  <= 1'b0;
            jn2_q  <= 1'b0;
        end else begin
            test_q <= test_d;
            jn1_q  <= jn1_d;
            jn2_q  <= jn2_d;
        end
    end

    // transitions and token moves
    always_comb begin
        t_choose = test_q;
        t_join   = jn1_q & jn2_q;
        t_seq    = done_i[OP_SEQ_A];
        t_merge  = t_join | done_i[OP_SEQ_B];

        fire_o               = '0;
        fire_o[OP_PAR_A]     = t_choose & cond_i;
        fire_o[OP_PAR_B]     = t_choose & cond_i;
        fire_o[OP_SEQ_A]     = t_choose & ~cond_i;
        fire_o[OP_SEQ_B]     = t_seq;

        test_d = t_merge;
        jn1_d  = (jn1_q & ~t_join) | done_i[OP_PAR_A];
        jn2_d  = (jn2_q & ~t_join) | done_i[OP_PAR_B];
    end

    always_comb begin
        marking_o          = '0;
        marking_o[PL_TEST] = test_q;
        marking_o[PL_RUN1] = busy_i[OP_PAR_A];
        marking_o[PL_RUN2] = busy_i[OP_PAR_B];
        marking_o[PL_JN1]  = jn1_q;
        marking_o[PL_JN2]  = jn2_q;
        marking_o[PL_RUN3] = busy_i[OP_SEQ_A];
        marking_o[PL_RUN4] = busy_i[OP_SEQ_B];
    end

    // R9: test place marked alone
    a_r9_test_alone: assert property (@(posedge clk) disable iff (!rst_n)
        test_q |-> (busy_i == '0 && !jn1_q && !jn2_q));

    // R8: the two branches never hold tokens together
    a_r8_branch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !((busy_i[OP_PAR_A] | busy_i[OP_PAR_B] | jn1_q | jn2_q) &&
          (busy_i[OP_SEQ_A] | busy_i[OP_SEQ_B])));

    // R5: a lone join place keeps its token
    a_r5_join_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (jn1_q && !jn2_q) |=> jn1_q);

    // R6: op4 starts only out of op3
    a_r6_seq_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i[OP_SEQ_B]) |-> $past(busy_i[OP_SEQ_A]));

    // R7: test place re-entered only from join or end of op4
    a_r7_merge_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_q) |-> ($past(jn1_q && jn2_q) || $past(busy_i[OP_SEQ_B])));

endmodule

// File: rtl/tokseq_ctrl.sv
module tokseq_ctrl
    import tokseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cond_i,
    input  logic [NUM_OPS-1:0]    ack_i,
    output logic [NUM_OPS-1:0]    req_o,
    output logic [NUM_PLACES-1:0] marking_o
);

    logic [NUM_OPS-1:0] fire;
    logic [NUM_OPS-1:0] busy;
    logic [NUM_OPS-1:0] done;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        hs_op_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire_i (fire[k]),
            .ack_i  (ack_i[k]),
            .req_o  (req_o[k]),
            .busy_o (busy[k]),
            .done_o (done[k])
        );
    end

    tok_net_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .busy_i    (busy),
        .done_i    (done),
        .fire_o    (fire),
        .marking_o (marking_o)
    );

    // R8: op3 and op4 never requested together
    a_r8_seq_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o[OP_SEQ_A] && req_o[OP_SEQ_B]));

endmodule

// File: tb/test_tokseq_ctrl.sv
module test_tokseq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cond = 1'b0;
    logic [3:0] ack = 4'b0;
    logic [3:0] req;
    logic [6:0] marking;

    always #5 clk = ~clk;   // 10 ns period

    tokseq_ctrl i_tokseq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond),
        .ack_i     (ack),
        .req_o     (req),
        .marking_o (marking)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // ---------------- behavioural model ----------------
    int m_ph [4];      // 0 empty, 1 requesting, 2 releasing
    bit m_test, m_j1, m_j2;
    int m_loops = 0;
    bit fin [4];
    bit st [4];
    bit nt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) m_ph[k] = 0;
            m_test = 1'b1; m_j1 = 1'b0; m_j2 = 1'b0;
        end else begin
            for (int k = 0; k < 4; k++) fin[k] = (m_ph[k] == 2) && !ack[k];
            st[0] = m_test && cond;
            st[1] = m_test && cond;
            st[2] = m_test && !cond;
            st[3] = fin[2];
            nt = (m_j1 && m_j2) || fin[3];
            if (m_j1 && m_j2) begin m_j1 = 1'b0; m_j2 = 1'b0; end
            if (fin[0]) m_j1 = 1'b1;
            if (fin[1]) m_j2 = 1'b1;
            for (int k = 0; k < 4; k++) begin
                if (m_ph[k] == 0 && st[k]) m_ph[k] = 1;
                else if (m_ph[k] == 1 && ack[k]) m_ph[k] = 2;
                else if (m_ph[k] == 2 && !ack[k]) m_ph[k] = 0;
            end
            if (nt && !m_test) m_loops++;
            m_test = nt;
        end
    end

    function automatic logic [6:0] exp_mark();
        logic [6:0] v;
        v[0] = m_test;
        v[1] = (m_ph[0] != 0);
        v[2] = (m_ph[1] != 0);
        v[3] = m_j1;
        v[4] = m_j2;
        v[5] = (m_ph[2] != 0);
        v[6] = (m_ph[3] != 0);
        return v;
    endfunction

    function automatic logic [3:0] exp_req();
        logic [3:0] v;
        for (int k = 0; k < 4; k++) v[k] = (m_ph[k] == 1);
        return v;
    endfunction

    task automatic chk(input string tag, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // ---------------- stimulus and checks ----------------
    int cnt [4];
    logic [6:0] p_mark;
    logic [3:0] p_req, p_ack;
    logic p_cond;
    bit rec_cond;
    bit in_branch = 1'b0;
    int dut_loops = 0;

    function automatic int dly(input int k);
        int mode;
        mode = (cyc / 800) % 4;
        case (mode)
            0: return 0;
            1: return (k == 1) ? 3 : 0;
            2: return (k == 0) ? 3 : 1;
            default: return $urandom_range(0, 3);
        endcase
    endfunction

    always @(negedge clk) begin
        if (!finished) begin
            cyc++;
            if (!rst_n) begin
                if (cyc == 3) begin
                    chk("R1 marking in reset", marking == 7'b0000001, 32'(marking), 32'h1);
                    chk("R1 requests in reset", req == 4'b0, 32'(req), 32'h0);
                    rst_n = 1'b1;
                    chk("R1 marking after release", marking == 7'b0000001, 32'(marking), 32'h1);
                end
            end else begin
                // model comparison every cycle
                chk("R2 marking vs model", marking == exp_mark(), 32'(marking), 32'(exp_mark()));
                chk("R4 requests vs model", req == exp_req(), 32'(req), 32'(exp_req()));
                // R9
                if (marking[0])
                    chk("R9 test place alone", marking[6:1] == 6'b0 && req == 4'b0,
                        32'(marking), 32'h1);
                // R8
                chk("R8 branch exclusion",
                    !((|marking[4:1]) && (|marking[6:5])) && !(req[2] && req[3]),
                    32'(marking), 32'h0);
                // R2 choice outcome
                if (p_mark[0]) begin
                    if (p_cond)
                        chk("R2 fork on true", marking == 7'b0000110 && req == 4'b0011,
                            {21'b0, req, marking}, {21'b0, 4'b0011, 7'b0000110});
                    else
                        chk("R2 op3 on false", marking == 7'b0100000 && req == 4'b0100,
                            {21'b0, req, marking}, {21'b0, 4'b0100, 7'b0100000});
                    rec_cond = p_cond;
                    in_branch = 1'b1;
                end
                // R3 branch held for the iteration
                if (marking[0]) in_branch = 1'b0;
                if (in_branch) begin
                    if (rec_cond)
                        chk("R3 stays in parallel branch", marking[6:5] == 2'b0,
                            32'(marking), 32'h0);
                    else
                        chk("R3 stays in sequential branch", marking[4:1] == 4'b0,
                            32'(marking), 32'h0);
                end
                // R4 request held while ack low
                for (int k = 0; k < 4; k++) begin
                    if (p_req[k] && !p_ack[k])
                        chk("R4 request held", req[k], 32'(req[k]), 32'h1);
                    if (p_req[k] && p_ack[k])
                        chk("R4 request dropped", !req[k], 32'(req[k]), 32'h0);
                end
                // R5 lone join place waits
                if (p_mark[3] != p_mark[4] && !p_mark[0])
                    chk("R5 join waits", marking[0] == 1'b0 &&
                        (p_mark[3] ? marking[3] : marking[4]), 32'(marking), 32'(p_mark));
                // R6 op4 starts right after op3 completes
                if (req[3] && !p_req[3])
                    chk("R6 op4 follows op3", p_mark[5] && !p_ack[2] && !p_req[2] &&
                        marking[6:5] == 2'b10, 32'(p_mark), 32'h20);
                // R7 merge timing
                if (marking[0] && !p_mark[0]) begin
                    dut_loops++;
                    chk("R7 merge source", (p_mark[3] && p_mark[4]) ||
                        (p_mark[6] && !p_ack[3] && !p_req[3]), 32'(p_mark), 32'h18);
                end
            end

            p_mark = marking;
            p_req  = req;

            // datapath responder
            for (int k = 0; k < 4; k++) begin
                if (req[k] != ack[k]) begin
                    if (cnt[k] > 0) cnt[k]--;
                    else begin
                        ack[k] = req[k];
                        cnt[k] = dly(k);
                    end
                end else begin
                    cnt[k] = dly(k);
                end
            end
            cond = 1'($urandom_range(0, 1));
            p_ack  = ack;
            p_cond = cond;

            if (cyc == 3400) begin
                chk("R7 loops match model", dut_loops == m_loops, 32'(dut_loops), 32'(m_loops));
                chk("R7 loop repeats", dut_loops > 100, 32'(dut_loops), 32'd101);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                finished = 1'b1;
                $finish;
            end
        end
    end

    initial begin
        p_mark = 7'b0; p_req = 4'b0; p_ack = 4'b0; p_cond = 1'b0; rec_cond = 1'b0;
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        #1500000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog cycle %0d actual=hung expected=done", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            finished = 1'b1;
            $finish;
        end
    end

endmodule